// File: doc/BRIEF.md
# UART Receive Status and Error Tracker

This block sits on the receive side of a 16550-class UART, between the receive shift logic and the host register interface. Each cycle the shift logic may hand it one assembled character together with three flags: parity error, framing error and break. The block stores characters in a single holding slot when FIFO mode is off, or in a 16-entry receive queue when FIFO mode is on. Each stored entry keeps its own flags. The block drives the receive half of the line status word: data ready, overrun, parity, framing, break and the queue-wide error bit. It also raises the receiver line-status interrupt.

The host side has two single-cycle strobes. A data read removes the character at the head of the storage. A status read clears the sticky error bits. A status read returns the values held before the strobe, and the clear takes effect on the next clock edge. Storage occupancy is tracked by a three-state machine. The states are `OCC_EMPTY`, `OCC_PART` and `OCC_FULL`, with these transitions:
- `OCC_EMPTY` to `OCC_PART` (first write in FIFO mode), or `OCC_EMPTY` to `OCC_FULL` (first write in holding mode).
- `OCC_PART` to `OCC_FULL` (last free slot taken).
- `OCC_PART` to `OCC_EMPTY` (last entry read).
- `OCC_FULL` to `OCC_PART` (a read from a full queue).
- `OCC_FULL` to `OCC_EMPTY` (a read from the holding slot).
- Any state to `OCC_EMPTY` when the mode changes.

A two-state break gate filters break characters. In `BRK_ARMED`, a break character is passed on and the gate moves to `BRK_HELD`. In `BRK_HELD`, further break characters are discarded, and the first non-break character moves the gate back to `BRK_ARMED`.

Top module: `uart_rx_status`

## Requirements
- R1: `st_data_ready` is 1 from the clock edge that stores a character until the edge at which a data read removes the last stored character; `host_rdata` always presents the oldest stored character.
- R2: With FIFO mode off, a character that arrives while the holding slot is unread replaces it. `host_rdata` then shows the newer character, and `st_overrun` becomes 1.
- R3: With FIFO mode on and 16 characters stored, an arriving character without a same-cycle data read is discarded, `st_overrun` becomes 1, and the 16 stored characters read out unchanged and in arrival order.
- R4: A status read leaves `st_overrun`, `st_parity_err`, `st_frame_err` and `st_break` at their pre-read values during the strobe cycle and clears them at the next edge. A set event in the same cycle wins over the clear.
- R5: In FIFO mode, `st_parity_err`, `st_frame_err` and `st_break` are loaded from the flags of each character as it becomes the head. A flagged character further back in the queue does not show in them.
- R6: A run of consecutive break characters stores exactly one entry, with data 0x00 and the break flag set. The next non-break character is stored normally.
- R7: `st_fifo_err` becomes 1 when a character with any flag is stored in FIFO mode. It is 0 whenever FIFO mode is off.
- R8: A status read clears `st_fifo_err` only if no flagged character remains stored at the time of the read.
- R9: `rls_irq` is 1 exactly when `ier_rls_en` is 1 and at least one of overrun, parity, framing or break status is 1.
- R10: After reset, every status output, `rls_irq` and `host_rdata` are 0.
- R11: A change of `fifo_en` empties the storage and clears `st_fifo_err` at the next edge.
- R12: With the queue full, a character arriving in the same cycle as a data read is stored, with no overrun, and becomes the last entry read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 the single holding slot |
| ier_rls_en | input | 1 | Receiver line-status interrupt enable |
| rx_valid | input | 1 | An assembled character is presented this cycle |
| rx_data | input | 8 | Assembled character |
| rx_parity_err | input | 1 | Parity flag of the character |
| rx_frame_err | input | 1 | Framing flag of the character |
| rx_break | input | 1 | Break flag of the character |
| host_data_rd | input | 1 | Host read strobe of the receive data register |
| host_lsr_rd | input | 1 | Host read strobe of the line status register |
| host_rdata | output | 8 | Oldest stored character, 0 when empty |
| st_data_ready | output | 1 | Data ready status |
| st_overrun | output | 1 | Overrun status |
| st_parity_err | output | 1 | Parity error status |
| st_frame_err | output | 1 | Framing error status |
| st_break | output | 1 | Break status |
| st_fifo_err | output | 1 | Queue-wide error status |
| rls_irq | output | 1 | Receiver line-status interrupt request |

## Verification
The bench fills the queue to exactly 16 entries and then sends a 17th character. A design that stored it, or that wrapped a pointer, would read out the wrong order or show data ready after 16 reads. It sends a character together with a data read while the queue is full, where a design with an off-by-one capacity test would report a false overrun or lose the character. It queues a clean character ahead of flagged ones to catch flags shown early or tied to the wrong entry. It status-reads while flagged entries remain, which catches a queue-wide error bit that clears too soon. It holds a break across several characters to catch a design that stores more than one zero character.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int RXS_DATA_W = 8;
    localparam int RXS_FLAG_W = 3;

    typedef struct packed {
        logic                  brk;
        logic                  fe;
        logic                  pe;
        logic [RXS_DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PART,
        OCC_FULL
    } occ_state_t;

    typedef enum logic {
        BRK_ARMED,
        BRK_HELD
    } brk_state_t;

    function automatic logic entry_flagged(rx_entry_t e);
        return e.brk | e.fe | e.pe;
    endfunction

endpackage

// File: rtl/rxs_break_gate.sv
module rxs_break_gate
    import rxs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  rx_entry_t in_entry,
    output logic      out_valid,
    output rx_entry_t out_entry
);

    brk_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BRK_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BRK_ARMED: if (in_valid && in_entry.brk)  state_d = BRK_HELD;
            BRK_HELD:  if (in_valid && !in_entry.brk) state_d = BRK_ARMED;
            default:   state_d = BRK_ARMED;
        endcase
    end

    always_comb begin
        out_valid = 1'b0;
        out_entry = in_entry;
        unique case (state_q)
            BRK_ARMED: begin
                out_valid = in_valid;
                if (in_entry.brk) out_entry = '{brk: 1'b1, fe: 1'b0, pe: 1'b0, data: '0};
            end
            BRK_HELD: out_valid = in_valid && !in_entry.brk;
            default:  out_valid = 1'b0;
        endcase
    end

    // R6: a break character seen while a break is held never reaches storage
    a_r6_held_break_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BRK_HELD && in_valid && in_entry.brk) |-> !out_valid);

    // R6: a break that is passed on arms the hold for the following cycle
    a_r6_break_arms_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_entry.brk) |=> (state_q == BRK_HELD));

endmodule

// File: rtl/rxs_store.sv
module rxs_store
    import rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fifo_en,
    input  logic                  flush,
    input  logic                  push,
    input  rx_entry_t             push_entry,
    input  logic                  pop,
    output rx_entry_t             head_entry,
    output logic                  has_data,
    output logic                  new_head,
    output logic [RXS_FLAG_W-1:0] new_head_flags,
    output logic                  overrun_evt,
    output logic                  flagged_write,
    output logic [CNT_W-1:0]      err_cnt
);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
    logic [CNT_W-1:0] count, count_d, err_d;
    occ_state_t       state_q, state_d;

    logic at_cap, pop_ok, append, overwrite, drop, cap_is_one;
    logic last_free, last_entry;
    rx_entry_t next_in_line;

    always_comb begin
        rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    end

    assign cap_is_one = !fifo_en;
    assign last_free  = (count == CNT_W'(DEPTH - 1));
    assign last_entry = (count == CNT_W'(1));

    // datapath decisions use the occupancy state
    always_comb begin
        has_data  = (state_q != OCC_EMPTY);
        at_cap    = (state_q == OCC_FULL);
        pop_ok    = pop && has_data && !flush;
        overwrite = !fifo_en && push && has_data && !pop_ok && !flush;
        drop      = fifo_en && push && at_cap && !pop_ok && !flush;
        append    = push && !flush && (!at_cap || pop_ok);
    end

    assign next_in_line  = mem[rd_nxt];
    assign overrun_evt   = overwrite || drop;
    assign flagged_write = (append || overwrite) && entry_flagged(push_entry);
    assign head_entry    = has_data ? mem[rd_ptr] : '0;

    always_comb begin
        new_head       = 1'b0;
        new_head_flags = {push_entry.brk, push_entry.fe, push_entry.pe};
        if (pop_ok && !last_entry) begin
            new_head       = 1'b1;
            new_head_flags = {next_in_line.brk, next_in_line.fe, next_in_line.pe};
        end else if (overwrite || (append && (!has_data || pop_ok))) begin
            new_head = 1'b1;
        end
    end

    // occupancy state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // occupancy state machine: transitions
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = OCC_EMPTY;
        end else begin
            unique case (state_q)
                OCC_EMPTY: if (append) state_d = cap_is_one ? OCC_FULL : OCC_PART;
                OCC_PART: begin
                    if (append && !pop_ok && last_free)      state_d = OCC_FULL;
                    else if (pop_ok && !append && last_entry) state_d = OCC_EMPTY;
                end
                OCC_FULL:  if (pop_ok && !append) state_d = cap_is_one ? OCC_EMPTY : OCC_PART;
                default:   state_d = OCC_EMPTY;
            endcase
        end
    end

    always_comb begin
        if (flush) begin
            count_d = '0;
            err_d   = '0;
        end else begin
            count_d = count + CNT_W'(append) - CNT_W'(pop_ok);
            err_d   = err_cnt + CNT_W'(flagged_write)
                    - CNT_W'((pop_ok || overwrite) && entry_flagged(mem[rd_ptr]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else begin
            count   <= count_d;
            err_cnt <= err_d;
            if (flush) begin
                rd_ptr <= '0;
                wr_ptr <= '0;
            end else begin
                if (pop_ok) rd_ptr <= rd_nxt;
                if (append) wr_ptr <= wr_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (append)         mem[wr_ptr] <= push_entry;
        else if (overwrite) mem[rd_ptr] <= push_entry;
    end

    // R1: empty state and zero count agree
    a_r1_empty_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_EMPTY) == (count == '0));

    // R3: the full state sits at the capacity of the current mode
    a_r3_full_at_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_FULL && !flush) |-> (count == (fifo_en ? CNT_W'(DEPTH) : CNT_W'(1))));

    // R3: a dropped character leaves the queue full
    a_r3_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (state_q == OCC_FULL));

    // R8: flagged entries never outnumber stored entries
    a_r8_err_within_count: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= count);

    // R11: a flush leaves nothing stored
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && err_cnt == '0));

endmodule

// File: rtl/rxs_status.sv
module rxs_status
    import rxs_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fifo_en,
    input  logic                  flush,
    input  logic                  ier_rls_en,
    input  logic                  lsr_rd,
    input  logic                  overrun_evt,
    input  logic                  new_head,
    input  logic [RXS_FLAG_W-1:0] new_head_flags,
    input  logic                  flagged_write,
    input  logic [CNT_W-1:0]      err_cnt,
    output logic                  oe,
    output logic                  pe,
    output logic                  fe,
    output logic                  bi,
    output logic                  fifo_err,
    output logic                  irq
);

    logic [RXS_FLAG_W-1:0] flags_q, flags_keep;
    logic                  oe_q, fifo_err_q;

    assign flags_keep = lsr_rd ? '0 : flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q    <= '0;
            oe_q       <= 1'b0;
            fifo_err_q <= 1'b0;
        end else begin
            flags_q <= flags_keep | (new_head ? new_head_flags : '0);
            oe_q    <= (oe_q && !lsr_rd) || overrun_evt;
            if (flush)
                fifo_err_q <= 1'b0;
            else if (flagged_write)
                fifo_err_q <= 1'b1;
            else if (lsr_rd && err_cnt == '0)
                fifo_err_q <= 1'b0;
        end
    end

    always_comb begin
        oe       = oe_q;
        pe       = flags_q[0];
        fe       = flags_q[1];
        bi       = flags_q[2];
        fifo_err = fifo_err_q && fifo_en;
        irq      = ier_rls_en && (oe_q || (|flags_q));
    end

    // R2: an overrun event shows on the following cycle
    a_r2_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_evt |=> oe);

    // R4: a status read with no new overrun clears the bit
    a_r4_read_clears_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !overrun_evt) |=> !oe);

    // R8: the queue-wide bit stays up while flagged entries remain
    a_r8_err_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt != '0) |-> fifo_err_q);

    // R9: no interrupt while the enable is low
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_rls_en |-> !irq);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       ier_rls_en,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_parity_err,
    input  logic       rx_frame_err,
    input  logic       rx_break,
    input  logic       host_data_rd,
    input  logic       host_lsr_rd,
    output logic [7:0] host_rdata,
    output logic       st_data_ready,
    output logic       st_overrun,
    output logic       st_parity_err,
    output logic       st_frame_err,
    output logic       st_break,
    output logic       st_fifo_err,
    output logic       rls_irq
);

    logic                  mode_q, flush;
    logic                  gate_valid;
    rx_entry_t             in_entry, gate_entry, head;
    logic                  has_data, new_head, overrun_evt, flagged_write;
    logic [RXS_FLAG_W-1:0] new_head_flags;
    logic [CNT_W-1:0]      err_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= fifo_en;
    end

    assign flush    = (fifo_en != mode_q);
    assign in_entry = '{brk: rx_break, fe: rx_frame_err, pe: rx_parity_err, data: rx_data};

    rxs_break_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_entry  (in_entry),
        .out_valid (gate_valid),
        .out_entry (gate_entry)
    );

    rxs_store #(.DEPTH(DEPTH)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .fifo_en        (fifo_en),
        .flush          (flush),
        .push           (gate_valid),
        .push_entry     (gate_entry),
        .pop            (host_data_rd),
        .head_entry     (head),
        .has_data       (has_data),
        .new_head       (new_head),
        .new_head_flags (new_head_flags),
        .overrun_evt    (overrun_evt),
        .flagged_write  (flagged_write),
        .err_cnt        (err_cnt)
    );

    rxs_status #(.CNT_W(CNT_W)) u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .fifo_en        (fifo_en),
        .flush          (flush),
        .ier_rls_en     (ier_rls_en),
        .lsr_rd         (host_lsr_rd),
        .overrun_evt    (overrun_evt),
        .new_head       (new_head),
        .new_head_flags (new_head_flags),
        .flagged_write  (flagged_write),
        .err_cnt        (err_cnt),
        .oe             (st_overrun),
        .pe             (st_parity_err),
        .fe             (st_frame_err),
        .bi             (st_break),
        .fifo_err       (st_fifo_err),
        .irq            (rls_irq)
    );

    assign host_rdata    = head.data;
    assign st_data_ready = has_data;

    // R1: a stored character raises data ready on the next cycle
    a_r1_store_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_valid && !flush) |=> st_data_ready);

    // R7: the queue-wide bit is silent outside FIFO mode
    a_r7_quiet_without_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !$past(fifo_en)) |-> !st_fifo_err);

endmodule

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       ier_rls_en = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_parity_err = 1'b0;
    logic       rx_frame_err = 1'b0;
    logic       rx_break = 1'b0;
    logic       host_data_rd = 1'b0;
    logic       host_lsr_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       st_data_ready, st_overrun, st_parity_err, st_frame_err;
    logic       st_break, st_fifo_err, rls_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uart_rx_status uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_en       (fifo_en),
        .ier_rls_en    (ier_rls_en),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_parity_err (rx_parity_err),
        .rx_frame_err  (rx_frame_err),
        .rx_break      (rx_break),
        .host_data_rd  (host_data_rd),
        .host_lsr_rd   (host_lsr_rd),
        .host_rdata    (host_rdata),
        .st_data_ready (st_data_ready),
        .st_overrun    (st_overrun),
        .st_parity_err (st_parity_err),
        .st_frame_err  (st_frame_err),
        .st_break      (st_break),
        .st_fifo_err   (st_fifo_err),
        .rls_irq       (rls_irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(logic [7:0] d, logic p, logic f, logic b);
        rx_valid = 1'b1; rx_data = d;
        rx_parity_err = p; rx_frame_err = f; rx_break = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_parity_err = 1'b0; rx_frame_err = 1'b0; rx_break = 1'b0;
    endtask

    task automatic data_read(string req, logic [7:0] exp);
        check(req, host_rdata, exp);
        host_data_rd = 1'b1;
        @(negedge clk);
        host_data_rd = 1'b0;
    endtask

    task automatic lsr_read;
        host_lsr_rd = 1'b1;
        @(negedge clk);
        host_lsr_rd = 1'b0;
    endtask

    task automatic set_mode(logic m);
        fifo_en = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R10 data_ready", st_data_ready, 0);
        check("R10 overrun", st_overrun, 0);
        check("R10 err bits", {st_parity_err, st_frame_err, st_break, st_fifo_err}, 0);
        check("R10 irq", rls_irq, 0);
        check("R10 rdata", host_rdata, 8'h00);
    endtask

    task automatic t_holding;
        set_mode(1'b0);
        ier_rls_en = 1'b1;
        send(8'h41, 0, 0, 0);
        check("R1 ready after store", st_data_ready, 1);
        check("R1 rdata", host_rdata, 8'h41);
        check("R9 irq quiet", rls_irq, 0);
        send(8'h42, 0, 0, 0);
        check("R2 overrun", st_overrun, 1);
        check("R2 newer kept", host_rdata, 8'h42);
        check("R9 irq on overrun", rls_irq, 1);
        host_lsr_rd = 1'b1;
        check("R4 value during read", st_overrun, 1);
        @(negedge clk);
        host_lsr_rd = 1'b0;
        check("R4 cleared after read", st_overrun, 0);
        // overrun event in the same cycle as a status read
        rx_valid = 1'b1; rx_data = 8'h43; host_lsr_rd = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; host_lsr_rd = 1'b0;
        check("R4 set wins over clear", st_overrun, 1);
        lsr_read();
        data_read("R1 read value", 8'h43);
        check("R1 ready clears", st_data_ready, 0);
        ier_rls_en = 1'b0;
        send(8'h66, 1, 0, 0);
        check("R5 parity in holding mode", st_parity_err, 1);
        check("R7 forced 0 off FIFO", st_fifo_err, 0);
        check("R9 irq disabled", rls_irq, 0);
        ier_rls_en = 1'b1;
        #1;
        check("R9 irq enabled", rls_irq, 1);
        lsr_read();
        check("R4 parity cleared", st_parity_err, 0);
        data_read("R1 holding read", 8'h66);
        ier_rls_en = 1'b0;
    endtask

    task automatic t_fill;
        set_mode(1'b1);
        for (int i = 0; i < 16; i++) send(8'h30 + 8'(i), 0, 0, 0);
        check("R3 no overrun at 16", st_overrun, 0);
        send(8'hEE, 0, 0, 0);
        check("R3 overrun on 17th", st_overrun, 1);
        lsr_read();
        for (int i = 0; i < 16; i++) data_read("R3 order", 8'h30 + 8'(i));
        check("R3 17th not stored", st_data_ready, 0);
    endtask

    task automatic t_simul;
        for (int i = 0; i < 16; i++) send(8'h60 + 8'(i), 0, 0, 0);
        check("R12 rdata before", host_rdata, 8'h60);
        rx_valid = 1'b1; rx_data = 8'h99; host_data_rd = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; host_data_rd = 1'b0;
        check("R12 no overrun", st_overrun, 0);
        for (int i = 1; i < 16; i++) data_read("R12 order", 8'h60 + 8'(i));
        data_read("R12 last entry", 8'h99);
        check("R12 empty", st_data_ready, 0);
    endtask

    task automatic t_flags;
        send(8'h10, 0, 0, 0);
        send(8'h20, 1, 0, 0);
        send(8'h30, 0, 1, 0);
        check("R5 clean head", {st_parity_err, st_frame_err}, 2'b00);
        check("R7 queue error", st_fifo_err, 1);
        lsr_read();
        check("R8 kept with errors stored", st_fifo_err, 1);
        data_read("R5 first", 8'h10);
        check("R5 parity at head", st_parity_err, 1);
        lsr_read();
        data_read("R5 second", 8'h20);
        check("R5 framing at head", {st_parity_err, st_frame_err}, 2'b01);
        lsr_read();
        check("R8 kept one left", st_fifo_err, 1);
        data_read("R5 third", 8'h30);
        check("R8 held until read", st_fifo_err, 1);
        lsr_read();
        check("R8 cleared", st_fifo_err, 0);
    endtask

    task automatic t_break;
        ier_rls_en = 1'b1;
        send(8'hFF, 0, 1, 1);
        send(8'hFF, 0, 1, 1);
        send(8'hFF, 0, 1, 1);
        send(8'h55, 0, 0, 0);
        check("R6 break at head", st_break, 1);
        check("R9 irq on break", rls_irq, 1);
        lsr_read();
        data_read("R6 zero char", 8'h00);
        data_read("R6 following char", 8'h55);
        check("R6 one break entry", st_data_ready, 0);
        lsr_read();
        ier_rls_en = 1'b0;
    endtask

    task automatic t_mode;
        send(8'h01, 0, 0, 0);
        send(8'h02, 0, 1, 0);
        check("R7 set", st_fifo_err, 1);
        fifo_en = 1'b0;
        #1;
        check("R7 masked off", st_fifo_err, 0);
        @(negedge clk);
        check("R11 emptied", st_data_ready, 0);
        set_mode(1'b1);
        check("R11 error bit cleared", st_fifo_err, 0);
        check("R11 still empty", st_data_ready, 0);
        lsr_read();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_holding();
        t_fill();
        t_simul();
        t_flags();
        t_break();
        t_mode();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule